// File: doc/BRIEF.md
# UART Modem Control and Status Logic

This block holds the modem control byte and the modem status byte of a 16550-style serial port. Software reaches both through a small byte-wide register port. The control byte drives the external handshake outputs. The status byte reports the current level and the change history of the four incoming modem lines. A modem-status interrupt request is raised whenever a change has been recorded.

An internal loopback mode lets software test itself without a modem. In this mode the incoming status lines are fed from the control bits instead of the pins, and the external handshake outputs are parked inactive. The block also gates the interrupt pin. When the second auxiliary output bit is clear, the pin is released and reads as undriven. When that bit is set, the pin carries either the block's own modem-status request or a single pending-interrupt input that stands in for the port's other interrupt sources.

The depth of the input synchronizers can be set by a parameter. A second parameter selects whether the two auxiliary outputs are also parked during loopback.

Top module: `uart_modem_ctl`

## Requirements
- R1: The control register is written with `wr_en_i` and `addr_i`=0. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback enable. A read with `addr_i`=0 returns these five bits, and bits 7..5 read as 0. Setting bit 5 (the automatic flow-control request) is accepted but changes no output and no readback.
- R2: Outside loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` follow control bits 0, 1, 2 and 3 from the cycle after the write.
- R3: While loopback is set, `dtr_o` and `rts_o` are 0. With `PARK_AUX`=1, `out1_o` and `out2_o` are also 0. When loopback is cleared, the outputs return to the current control bit values.
- R4: In loopback, the status levels come from the control bits: RTS gives CTS (status bit 4), DTR gives DSR (bit 5), OUT1 gives RI (bit 6) and OUT2 gives DCD (bit 7). The external inputs have no effect.
- R5: Status bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) are set on any change of the matching effective line. This includes a change caused by entering or leaving loopback. Once set, these bits stay set until they are cleared by a read.
- R6: Status bit 2 is set only when the effective RI line falls from 1 to 0. A rising RI edge sets no bit.
- R7: A read with `addr_i`=1 and `rd_en_i` returns the status byte in that cycle and then clears bits 3..0. A change detected in the same cycle as the read still sets its bit.
- R8: Outside loopback, `cts_i`, `dsr_i`, `ri_i` and `dcd_i` pass through `SYNC_STAGES` flops before they reach the status byte. A change becomes visible after `SYNC_STAGES`+1 clock edges.
- R9: `msi_o` is high exactly when `msi_en_i` is high and at least one of status bits 3..0 is set.
- R10: `irq_oe_o` equals control bit 3 (OUT2). `irq_o` is `msi_o` OR `other_pend_i` while OUT2 is set, and 0 otherwise. Both change in the cycle after the write that changes OUT2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears change bits on a status read) |
| addr_i | input | 1 | 0 selects the control register, 1 selects the status register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| cts_i | input | 1 | External clear-to-send, active high |
| dsr_i | input | 1 | External data-set-ready, active high |
| ri_i | input | 1 | External ring indicator, active high |
| dcd_i | input | 1 | External carrier detect, active high |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | Auxiliary output 1 |
| out2_o | output | 1 | Auxiliary output 2 |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| other_pend_i | input | 1 | Pending request from the port's other interrupt sources |
| msi_o | output | 1 | Modem-status interrupt request |
| irq_o | output | 1 | Gated interrupt level |
| irq_oe_o | output | 1 | Drive enable of the interrupt pin; low means released |

## Verification
The bench builds the block with `SYNC_STAGES`=3 and `PARK_AUX`=1. The deeper synchronizer lets the bench confirm that an external change is still hidden after three edges and appears on the fourth. Parking the auxiliary outputs lets the bench confirm that loopback silences all four outputs, while OUT2 still gates the interrupt pin from inside the register.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
   localparam int CTL_W    = 5;
   localparam int B_DTR    = 0;
   localparam int B_RTS    = 1;
   localparam int B_AUX1   = 2;
   localparam int B_AUX2   = 3;
   localparam int B_LOOP   = 4;
   localparam int LINE_W   = 4;
   localparam int L_CTS    = 0;
   localparam int L_DSR    = 1;
   localparam int L_RI     = 2;
   localparam int L_DCD    = 3;
   localparam int BYTE_W   = 8;
   localparam logic A_CTL  = 1'b0;
   localparam logic A_STAT = 1'b1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial assert (STAGES >= 2) else $fatal(1, "mdm_sync: STAGES below 2");

   logic [WIDTH-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
   import uart_mdm_pkg::*;
#(
   parameter bit PARK_AUX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CTL_W-1:0]  wdata_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [LINE_W-1:0] lb_o,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              aux1_o,
   output logic              aux2_o
);
   logic [CTL_W-1:0] ctl_q;
   logic             loop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (we_i) ctl_q <= wdata_i;
   end

   assign loop  = ctl_q[B_LOOP];
   assign ctl_o = ctl_q;

   assign lb_o[L_CTS] = ctl_q[B_RTS];
   assign lb_o[L_DSR] = ctl_q[B_DTR];
   assign lb_o[L_RI]  = ctl_q[B_AUX1];
   assign lb_o[L_DCD] = ctl_q[B_AUX2];

   assign dtr_o = ctl_q[B_DTR] & ~loop;
   assign rts_o = ctl_q[B_RTS] & ~loop;

   generate
      if (PARK_AUX) begin : g_park
         assign aux1_o = ctl_q[B_AUX1] & ~loop;
         assign aux2_o = ctl_q[B_AUX2] & ~loop;
      end else begin : g_free
         assign aux1_o = ctl_q[B_AUX1];
         assign aux2_o = ctl_q[B_AUX2];
      end
   endgenerate

   AST_LOOP_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_LOOP] |-> (!dtr_o && !rts_o)); // R3
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
   import uart_mdm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_i,
   input  logic [LINE_W-1:0] lb_i,
   input  logic [LINE_W-1:0] ext_i,
   input  logic              clr_i,
   output logic [BYTE_W-1:0] stat_o,
   output logic              any_o
);
   logic [LINE_W-1:0] cur, lvl_q, chg_q, set_d;

   assign cur = loop_i ? lb_i : ext_i;

   genvar i;
   generate
      for (i = 0; i < LINE_W; i++) begin : g_det
         if (i == L_RI) begin : g_trail
            assign set_d[i] = lvl_q[i] & ~cur[i];
         end else begin : g_any
            assign set_d[i] = lvl_q[i] ^ cur[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         chg_q <= '0;
      end else begin
         lvl_q <= cur;
         chg_q <= (clr_i ? '0 : chg_q) | set_d;
      end
   end

   assign stat_o = {lvl_q, chg_q};
   assign any_o  = |chg_q;

   AST_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_q[L_RI]) |-> ($past(lvl_q[L_RI]) && !lvl_q[L_RI])); // R6
   AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_i) |-> ((chg_q & $past(chg_q)) == $past(chg_q))); // R5
   AST_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_i) && !$past(|set_d)) |-> (chg_q == '0)); // R7
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
   import uart_mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit PARK_AUX    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic       rd_en_i,
   input  logic       addr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o,
   input  logic       cts_i,
   input  logic       dsr_i,
   input  logic       ri_i,
   input  logic       dcd_i,
   output logic       dtr_o,
   output logic       rts_o,
   output logic       out1_o,
   output logic       out2_o,
   input  logic       msi_en_i,
   input  logic       other_pend_i,
   output logic       msi_o,
   output logic       irq_o,
   output logic       irq_oe_o
);
   localparam int PAD_W = BYTE_W - CTL_W;

   initial assert (SYNC_STAGES >= 2) else $fatal(1, "uart_modem_ctl: SYNC_STAGES below 2");

   logic [CTL_W-1:0]  ctl;
   logic [LINE_W-1:0] lb, ext_raw, ext_s;
   logic [BYTE_W-1:0] stat;
   logic              any_chg, ctl_we, stat_clr, irq_lvl;

   assign ctl_we   = wr_en_i && (addr_i == A_CTL);
   assign stat_clr = rd_en_i && (addr_i == A_STAT);

   assign ext_raw[L_CTS] = cts_i;
   assign ext_raw[L_DSR] = dsr_i;
   assign ext_raw[L_RI]  = ri_i;
   assign ext_raw[L_DCD] = dcd_i;

   mdm_ctl_reg #(.PARK_AUX(PARK_AUX)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we_i(ctl_we), .wdata_i(wdata_i[CTL_W-1:0]),
      .ctl_o(ctl), .lb_o(lb), .dtr_o(dtr_o), .rts_o(rts_o),
      .aux1_o(out1_o), .aux2_o(out2_o)
   );

   mdm_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ext_raw), .q_o(ext_s)
   );

   mdm_stat_reg u_stat (
      .clk(clk), .rst_n(rst_n), .loop_i(ctl[B_LOOP]), .lb_i(lb), .ext_i(ext_s),
      .clr_i(stat_clr), .stat_o(stat), .any_o(any_chg)
   );

   assign rdata_o  = (addr_i == A_STAT) ? stat : {{PAD_W{1'b0}}, ctl};
   assign msi_o    = msi_en_i & any_chg;
   assign irq_lvl  = msi_o | other_pend_i;
   assign irq_oe_o = ctl[B_AUX2];
   assign irq_o    = irq_oe_o & irq_lvl;

   AST_IRQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_oe_o |-> !irq_o); // R10
   AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_oe_o && other_pend_i) |-> irq_o); // R10
   AST_MSI_NEEDS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      msi_o |-> (stat[3:0] != 4'h0)); // R9
endmodule

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, addr = 0;
   logic [7:0] wdata = 0, rdata;
   logic cts = 0, dsr = 0, ri = 0, dcd = 0;
   logic dtr_o, rts_o, out1_o, out2_o;
   logic msi_en = 0, other = 0, msi, irq, irq_oe;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uart_modem_ctl #(.SYNC_STAGES(3), .PARK_AUX(1'b1)) u_uart_modem_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .cts_i(cts), .dsr_i(dsr), .ri_i(ri),
      .dcd_i(dcd), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
      .msi_en_i(msi_en), .other_pend_i(other), .msi_o(msi), .irq_o(irq),
      .irq_oe_o(irq_oe)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = 0; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd_ctl(output logic [7:0] v);
      @(negedge clk); addr = 0; #1 v = rdata;
   endtask

   task automatic rd_stat(output logic [7:0] v);
      @(negedge clk); addr = 1; rd_en = 1; #1 v = rdata;
      @(negedge clk); rd_en = 0; addr = 0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd_ctl(v); chk("R1 reset ctl", v, 8'h00);
      rd_stat(v); chk("R5 reset stat", v, 8'h00);
      chk("R2 reset pins", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h00);
      chk("R10 reset irq", {6'h0, irq_oe, irq}, 8'h00);
   endtask

   task automatic t_ctl();
      logic [7:0] v;
      wr(8'h0F); rd_ctl(v); chk("R1 readback", v, 8'h0F);
      chk("R2 pins follow", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h0F);
      wr(8'h2F); rd_ctl(v); chk("R1 flow bit ignored readback", v, 8'h0F);
      chk("R1 flow bit pins", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h0F);
      wr(8'h02);
      chk("R2 pins partial", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h02);
      wr(8'h00);
   endtask

   task automatic t_ext();
      logic [7:0] v;
      @(negedge clk); cts = 1; dsr = 1;
      idle(3); addr = 1; #1 chk("R8 hidden after 3 edges", rdata, 8'h00);
      idle(1); #1 chk("R8 visible after 4 edges", rdata, 8'h33);
      rd_stat(v); chk("R7 read returns", v, 8'h33);
      rd_stat(v); chk("R7 cleared", v, 8'h30);
      @(negedge clk); ri = 1; idle(6);
      rd_stat(v); chk("R6 rising RI no bit", v, 8'h70);
      @(negedge clk); ri = 0; idle(6);
      rd_stat(v); chk("R6 falling RI sets bit2", v, 8'h34);
      @(negedge clk); cts = 0; dsr = 0; idle(6);
      rd_stat(v); chk("R5 falling CTS DSR", v, 8'h03);
      rd_stat(v); chk("R7 empty", v, 8'h00);
   endtask

   task automatic t_loop();
      logic [7:0] v;
      @(negedge clk); cts = 1; dsr = 1; ri = 1; dcd = 1; idle(6);
      rd_stat(v); rd_stat(v); chk("R8 all lines high", v, 8'hF0);
      wr(8'h10); idle(1);
      rd_stat(v); chk("R5 entering loopback changes", v, 8'h0F);
      wr(8'h13);
      chk("R3 parked in loopback", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h00);
      idle(1); rd_stat(v); chk("R4 RTS DTR map", v, 8'h33);
      wr(8'h1F);
      chk("R3 aux parked", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h00);
      idle(1); rd_stat(v); chk("R4 OUT1 OUT2 map", v, 8'hF8);
      @(negedge clk); cts = 0; dsr = 0; ri = 0; dcd = 0; idle(6);
      rd_stat(v); chk("R4 external ignored", v, 8'hF0);
      wr(8'h1B); idle(1);
      rd_stat(v); chk("R6 OUT1 falling", v, 8'hB4);
      wr(8'h03);
      chk("R3 restored on exit", {4'h0, out2_o, out1_o, rts_o, dtr_o}, 8'h03);
      idle(1); rd_stat(v); chk("R5 leaving loopback changes", v, 8'h0B);
      rd_stat(v); chk("R7 empty after loop", v, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      @(negedge clk); msi_en = 1; other = 1; #1
      chk("R10 released while OUT2 low", {6'h0, irq_oe, irq}, 8'h00);
      wr(8'h0B);
      chk("R10 pending driven at once", {6'h0, irq_oe, irq}, 8'h03);
      wr(8'h03);
      chk("R10 removed at once", {6'h0, irq_oe, irq}, 8'h00);
      @(negedge clk); other = 0; cts = 1; idle(6); #1
      chk("R9 msi raised", {7'h0, msi}, 8'h01);
      chk("R10 msi gated", {7'h0, irq}, 8'h00);
      msi_en = 0; #1 chk("R9 msi disabled", {7'h0, msi}, 8'h00);
      msi_en = 1;
      wr(8'h0B); chk("R10 msi reaches pin", {7'h0, irq}, 8'h01);
      rd_stat(v); chk("R9 read clears msi", {6'h0, msi, irq}, 8'h00);
      @(negedge clk); cts = 0; idle(6); rd_stat(v);
      chk("R5 CTS fall", v, 8'h01);
   endtask

   initial begin
      idle(3); rst_n = 1; idle(2);
      t_reset();
      t_ctl();
      t_ext();
      t_loop();
      t_irq();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule